// File: doc/BRIEF.md
# Bus Cycle Ready-Handshake Tracker

This block closes each external bus cycle on the processor side. When a cycle starts, the bus unit names its kind. The kinds are a single read, a single write, a burst read (line fill), a burst writeback, a special cycle, and either half of an interrupt acknowledge pair. The tracker counts the ready strobes that system logic returns and records the data bus, parity and bus-check inputs on each strobe that counts. It records the cacheability, write-policy and parity-enable inputs by per-kind rules. On the last expected strobe it gives a one-clock done pulse.

It also holds off further writes. After a write cycle starts, another write cannot be accepted until the write-buffer-empty input has been seen high in a clock that has, or follows, a ready of that write. Strobes that arrive when no cycle is open are dropped. Next-address strobes that arrive when no cycle is open are also dropped.

The controller has three states. **ST_IDLE** waits for a start. **ST_FIRST** waits for the first ready of the cycle. **ST_BURST** collects the remaining beats of a burst. The transitions are:

- **T_ACCEPT**: ST_IDLE to ST_FIRST, on an accepted start.
- **T_SINGLE_END**: ST_FIRST to ST_IDLE, on ready for a single-strobe kind.
- **T_BURST_GO**: ST_FIRST to ST_BURST, on ready for a burst kind.
- **T_BURST_END**: ST_BURST to ST_IDLE, on the fourth ready.
- **T_HOLD**: no state change in all other clocks.

Top module: `bus_ready_tracker`

## Requirements
- R1: After reset `busy`, `done`, `xfer_valid` and `write_blocked` are 0, and `cache_q`, `wbwt_q`, `pen_q` are 0.
- R2: Kind codes on `cyc_type` are 0 single read, 1 single write, 2 burst read, 3 burst writeback, 4 special, 5 acknowledge first half, 6 acknowledge second half, and 7 is handled as special. A `start` is accepted only while `busy` is 0, and not for kinds 1 or 3 while `write_blocked` is 1. An accepted start makes `busy` 1 on the next clock.
- R3: Kinds 0, 1, 4, 5, 6 and 7 end on their first ready. `done` and `xfer_valid` are 1 for exactly one clock, the clock after that ready's edge, with `xfer_idx` 0.
- R4: Kinds 2 and 3 need four readies, whether gapped or back-to-back. Each ready yields `xfer_valid` with `xfer_idx` 0, 1, 2, 3 in turn, and `done` comes only with index 3.
- R5: A ready while no cycle is open (surplus strobes included) gives no `xfer_valid`, no `done`, and leaves the captured data unchanged.
- R6: On every counted ready, `data_q`, `par_q` and `bus_chk_q` take the values of `data_in`, `par_in` and `bus_chk` from that clock.
- R7: For kinds 0 and 2, `cache_q` takes `cache_in` from the first clock of the cycle in which ready or next-address is high. It takes it once per cycle. For other kinds `cache_q` is 0.
- R8: For kinds 0 to 3, `wbwt_q` takes `wbwt_in` under the same first-strobe rule. For other kinds it is 0.
- R9: `pen_q` takes `pen_in` on every ready of kinds 0 and 2 and on the ready of kind 6. It is cleared to 0 when a cycle is accepted.
- R10: `wbuf_empty_q` takes `wbuf_empty_in` on every ready of kinds 1 and 3.
- R11: An accepted write (kind 1 or 3) sets `write_blocked`. It clears after the edge of a clock where `wbuf_empty_in` is 1 and a ready of that write is present in the same clock or has already been seen.
- R12: `next_addr` while no cycle is open, or after the first-strobe capture of a cycle, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to open a cycle |
| cyc_type | input | 3 | Kind of the cycle being started |
| ready | input | 1 | Ready strobe from system logic |
| next_addr | input | 1 | Next-address strobe from system logic |
| data_in | input | 64 | Data bus |
| par_in | input | 8 | Data parity bits |
| bus_chk | input | 1 | Bus-check input |
| cache_in | input | 1 | Cacheability input |
| pen_in | input | 1 | Parity-enable input |
| wbwt_in | input | 1 | Writeback/writethrough input |
| wbuf_empty_in | input | 1 | External write buffer empty |
| busy | output | 1 | A cycle is open |
| done | output | 1 | One-clock pulse when the cycle is finished |
| xfer_valid | output | 1 | A counted ready was captured |
| xfer_idx | output | 2 | Index of the captured transfer |
| data_q | output | 64 | Captured data |
| par_q | output | 8 | Captured parity |
| bus_chk_q | output | 1 | Captured bus check |
| cache_q | output | 1 | Captured cacheability |
| wbwt_q | output | 1 | Captured write policy |
| pen_q | output | 1 | Captured parity enable |
| wbuf_empty_q | output | 1 | Captured write-buffer-empty |
| write_blocked | output | 1 | Further writes are held off |

## Verification
Every result is registered one edge deep. A ready, next-address or start driven in a clock shows at the outputs just after the next rising edge: `xfer_valid`, `done`, the captures, `busy` and `write_blocked` all change there. The bench drives inputs on the falling edge. It updates its own model of the requirements for that clock, then compares the outputs a short delay after the following rising edge, so each expected value is checked in the exact clock it is due. Random cycle kinds, ready gaps and next-address strobes are mixed with directed cases: back-to-back burst readies, surplus readies, next-address with no open cycle, and a write refused while blocked.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [2:0] {
        CYC_RD_SINGLE   = 3'd0,
        CYC_WR_SINGLE   = 3'd1,
        CYC_RD_BURST    = 3'd2,
        CYC_WB_BURST    = 3'd3,
        CYC_SPECIAL     = 3'd4,
        CYC_ACK_FIRST   = 3'd5,
        CYC_ACK_SECOND  = 3'd6,
        CYC_RESERVED    = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2
    } st_e;

    function automatic logic kind_is_read(input logic [2:0] k);
        return (k == CYC_RD_SINGLE) || (k == CYC_RD_BURST);
    endfunction

    function automatic logic kind_is_write(input logic [2:0] k);
        return (k == CYC_WR_SINGLE) || (k == CYC_WB_BURST);
    endfunction

    function automatic logic kind_is_burst(input logic [2:0] k);
        return (k == CYC_RD_BURST) || (k == CYC_WB_BURST);
    endfunction

    function automatic logic kind_takes_pen(input logic [2:0] k);
        return kind_is_read(k) || (k == CYC_ACK_SECOND);
    endfunction

endpackage

// File: rtl/brt_beat_counter.sv
module brt_beat_counter #(
    parameter int BEATS = 4,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             burst,
    output logic [IDX_W-1:0] idx,
    output logic             last_beat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (step && !last_beat) begin
            idx <= idx + 1'b1;
        end
    end

    assign last_beat = !burst || (idx == LAST_IDX);

endmodule

// File: rtl/brt_attr_capture.sv
module brt_attr_capture
    import brt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open_cyc,
    input  logic       active,
    input  logic [2:0] kind,
    input  logic       ready,
    input  logic       next_addr,
    input  logic       cache_in,
    input  logic       wbwt_in,
    input  logic       pen_in,
    input  logic       wbuf_in,
    output logic       cache_q,
    output logic       wbwt_q,
    output logic       pen_q,
    output logic       wbuf_q
);

    logic first_taken;
    logic first_strobe;
    logic beat;

    assign beat         = active && ready;
    assign first_strobe = active && (ready || next_addr) && !first_taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_taken <= 1'b0;
            cache_q     <= 1'b0;
            wbwt_q      <= 1'b0;
            pen_q       <= 1'b0;
            wbuf_q      <= 1'b0;
        end else if (open_cyc) begin
            first_taken <= 1'b0;
            cache_q     <= 1'b0;
            wbwt_q      <= 1'b0;
            pen_q       <= 1'b0;
        end else begin
            if (first_strobe) begin
                first_taken <= 1'b1;
                if (kind_is_read(kind)) begin
                    cache_q <= cache_in;
                end
                if (kind_is_read(kind) || kind_is_write(kind)) begin
                    wbwt_q <= wbwt_in;
                end
            end
            if (beat && kind_takes_pen(kind)) begin
                pen_q <= pen_in;
            end
            if (beat && kind_is_write(kind)) begin
                wbuf_q <= wbuf_in;
            end
        end
    end

endmodule

// File: rtl/brt_write_gate.sv
module brt_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_open,
    input  logic wr_beat,
    input  logic wbuf_in,
    output logic blocked
);

    logic beat_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked   <= 1'b0;
            beat_seen <= 1'b0;
        end else if (wr_open) begin
            blocked   <= 1'b1;
            beat_seen <= 1'b0;
        end else begin
            if (wr_beat) begin
                beat_seen <= 1'b1;
            end
            if (blocked && wbuf_in && (beat_seen || wr_beat)) begin
                blocked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_ready_tracker.sv
module bus_ready_tracker
    import brt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PAR_W  = 8,
    parameter int BEATS  = 4,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cyc_type,
    input  logic              ready,
    input  logic              next_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [PAR_W-1:0]  par_in,
    input  logic              bus_chk,
    input  logic              cache_in,
    input  logic              pen_in,
    input  logic              wbwt_in,
    input  logic              wbuf_empty_in,
    output logic              busy,
    output logic              done,
    output logic              xfer_valid,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic [DATA_W-1:0] data_q,
    output logic [PAR_W-1:0]  par_q,
    output logic              bus_chk_q,
    output logic              cache_q,
    output logic              wbwt_q,
    output logic              pen_q,
    output logic              wbuf_empty_q,
    output logic              write_blocked
);

    st_e              state, state_nx;
    logic [2:0]       kind;
    logic             accept;
    logic             beat;
    logic             last_beat;
    logic [IDX_W-1:0] beat_idx;

    assign busy   = (state != ST_IDLE);
    assign accept = (state == ST_IDLE) && start &&
                    !(kind_is_write(cyc_type) && write_blocked);
    assign beat   = busy && ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_FIRST;
            end
            ST_FIRST: begin
                if (ready) begin
                    state_nx = kind_is_burst(kind) ? ST_BURST : ST_IDLE;
                end
            end
            ST_BURST: begin
                if (ready && last_beat) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kind  <= 3'd0;
        end else begin
            state <= state_nx;
            if (accept) kind <= cyc_type;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            xfer_valid <= 1'b0;
            xfer_idx   <= '0;
            data_q     <= '0;
            par_q      <= '0;
            bus_chk_q  <= 1'b0;
        end else begin
            done       <= beat && last_beat;
            xfer_valid <= beat;
            if (beat) begin
                xfer_idx  <= beat_idx;
                data_q    <= data_in;
                par_q     <= par_in;
                bus_chk_q <= bus_chk;
            end
        end
    end

    brt_beat_counter #(.BEATS(BEATS)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (beat),
        .burst     (kind_is_burst(kind)),
        .idx       (beat_idx),
        .last_beat (last_beat)
    );

    brt_attr_capture u_attr (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_cyc  (accept),
        .active    (busy),
        .kind      (kind),
        .ready     (ready),
        .next_addr (next_addr),
        .cache_in  (cache_in),
        .wbwt_in   (wbwt_in),
        .pen_in    (pen_in),
        .wbuf_in   (wbuf_empty_in),
        .cache_q   (cache_q),
        .wbwt_q    (wbwt_q),
        .pen_q     (pen_q),
        .wbuf_q    (wbuf_empty_q)
    );

    brt_write_gate u_wgate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_open (accept && kind_is_write(cyc_type)),
        .wr_beat (beat && kind_is_write(kind)),
        .wbuf_in (wbuf_empty_in),
        .blocked (write_blocked)
    );

endmodule

// File: rtl/brt_checker.sv
module brt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  cyc_type,
    input logic        ready,
    input logic [63:0] data_in,
    input logic        busy,
    input logic        done,
    input logic        xfer_valid,
    input logic [63:0] data_q,
    input logic        write_blocked
);

    logic wr_kind;
    assign wr_kind = (cyc_type == 3'd1) || (cyc_type == 3'd3);

    p_done_single_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> xfer_valid);

    p_idle_ready_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ready) |=> !xfer_valid);

    p_data_follows_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |=> (data_q == $past(data_in)));

    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !(wr_kind && write_blocked)) |=> busy);

    p_write_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && wr_kind && write_blocked) |=> !busy);

endmodule

bind bus_ready_tracker brt_checker u_brt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cyc_type      (cyc_type),
    .ready         (ready),
    .data_in       (data_in),
    .busy          (busy),
    .done          (done),
    .xfer_valid    (xfer_valid),
    .data_q        (data_q),
    .write_blocked (write_blocked)
);

// File: tb/test_bus_ready_tracker.sv
module test_bus_ready_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cyc_type = 3'd0;
    logic        ready = 1'b0;
    logic        next_addr = 1'b0;
    logic [63:0] data_in = '0;
    logic [7:0]  par_in = '0;
    logic        bus_chk = 1'b0;
    logic        cache_in = 1'b0;
    logic        pen_in = 1'b0;
    logic        wbwt_in = 1'b0;
    logic        wbuf_empty_in = 1'b0;
    logic        busy, done, xfer_valid;
    logic [1:0]  xfer_idx;
    logic [63:0] data_q;
    logic [7:0]  par_q;
    logic        bus_chk_q, cache_q, wbwt_q, pen_q, wbuf_empty_q, write_blocked;

    int checks = 0;
    int failures = 0;

    // model state
    logic       m_busy = 0, m_attr = 0, m_blocked = 0, m_seen = 0;
    logic [2:0] m_type = 0;
    int         m_cnt = 0;
    logic       e_done = 0, e_valid = 0, e_cache = 0, e_wbwt = 0, e_pen = 0, e_wbuf = 0, e_bchk = 0;
    logic [1:0] e_idx = 0;
    logic [63:0] e_data = 0;
    logic [7:0]  e_par = 0;

    always #4 clk = ~clk;

    bus_ready_tracker i_bus_ready_tracker (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
        .ready(ready), .next_addr(next_addr), .data_in(data_in), .par_in(par_in),
        .bus_chk(bus_chk), .cache_in(cache_in), .pen_in(pen_in), .wbwt_in(wbwt_in),
        .wbuf_empty_in(wbuf_empty_in), .busy(busy), .done(done),
        .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .data_q(data_q), .par_q(par_q),
        .bus_chk_q(bus_chk_q), .cache_q(cache_q), .wbwt_q(wbwt_q), .pen_q(pen_q),
        .wbuf_empty_q(wbuf_empty_q), .write_blocked(write_blocked)
    );

    function automatic logic f_rd(input logic [2:0] k); return k == 3'd0 || k == 3'd2; endfunction
    function automatic logic f_wr(input logic [2:0] k); return k == 3'd1 || k == 3'd3; endfunction
    function automatic int   f_beats(input logic [2:0] k); return (k == 3'd2 || k == 3'd3) ? 4 : 1; endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string tag_done;
        tag_done = (f_beats(m_type) == 4) ? "R4 done" : "R3 done";
        chk(busy == m_busy, "R2 busy", busy, m_busy);
        chk(done == e_done, tag_done, done, e_done);
        chk(xfer_valid == e_valid, "R5 xfer_valid", xfer_valid, e_valid);
        if (e_valid) begin
            chk(xfer_idx == e_idx, "R4 xfer_idx", xfer_idx, e_idx);
        end
        chk(data_q == e_data, "R6 data_q", data_q, e_data);
        chk(par_q == e_par, "R6 par_q", par_q, e_par);
        chk(bus_chk_q == e_bchk, "R6 bus_chk_q", bus_chk_q, e_bchk);
        chk(cache_q == e_cache, "R7 cache_q", cache_q, e_cache);
        chk(wbwt_q == e_wbwt, "R8 wbwt_q", wbwt_q, e_wbwt);
        chk(pen_q == e_pen, "R9 pen_q", pen_q, e_pen);
        chk(wbuf_empty_q == e_wbuf, "R10 wbuf_empty_q", wbuf_empty_q, e_wbuf);
        chk(write_blocked == m_blocked, "R11 write_blocked", write_blocked, m_blocked);
    endtask

    // one clock: drive on falling edge, advance model, check after rising edge
    task automatic tick(input logic st, input logic [2:0] k, input logic rd, input logic na, input logic wb);
        logic was_busy;
        logic wr_beat;
        @(negedge clk);
        start = st; cyc_type = k; ready = rd; next_addr = na; wbuf_empty_in = wb;
        data_in = {$urandom, $urandom}; par_in = 8'($urandom);
        bus_chk = 1'($urandom); cache_in = 1'($urandom);
        pen_in = 1'($urandom); wbwt_in = 1'($urandom);
        was_busy = m_busy;
        wr_beat = was_busy && rd && f_wr(m_type);
        e_valid = 0; e_done = 0;
        if (!was_busy) begin
            if (st && !(f_wr(k) && m_blocked)) begin
                m_busy = 1; m_type = k; m_cnt = 0; m_attr = 0;
                e_cache = 0; e_wbwt = 0; e_pen = 0;
                if (f_wr(k)) begin m_blocked = 1; m_seen = 0; end
            end
        end else begin
            if ((rd || na) && !m_attr) begin
                m_attr = 1;
                if (f_rd(m_type)) e_cache = cache_in;
                if (f_rd(m_type) || f_wr(m_type)) e_wbwt = wbwt_in;
            end
            if (rd) begin
                e_valid = 1; e_idx = 2'(m_cnt);
                e_data = data_in; e_par = par_in; e_bchk = bus_chk;
                if (f_rd(m_type) || m_type == 3'd6) e_pen = pen_in;
                if (f_wr(m_type)) e_wbuf = wb;
                if (m_cnt == f_beats(m_type) - 1) begin
                    e_done = 1; m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        if (!(st && !was_busy && f_wr(k) && m_busy)) begin
            if (m_blocked && wb && (m_seen || wr_beat)) m_blocked = 0;
            if (wr_beat) m_seen = 1;
        end
        @(posedge clk);
        #2;
        check_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [63:0] hold;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(busy == 0 && done == 0 && xfer_valid == 0 && write_blocked == 0, "R1 flags", {busy, done, xfer_valid, write_blocked}, 0);
        chk(cache_q == 0 && wbwt_q == 0 && pen_q == 0, "R1 attrs", {cache_q, wbwt_q, pen_q}, 0);
        @(negedge clk); rst_n = 1;

        // R3 single read: next-address first, then ready
        tick(1, 3'd0, 0, 0, 0);
        tick(0, 3'd0, 0, 1, 0);
        tick(0, 3'd0, 0, 1, 0);   // R12 later next-address ignored
        tick(0, 3'd0, 1, 0, 0);
        // R5 surplus readies
        hold = data_q;
        tick(0, 3'd0, 1, 0, 0);
        tick(0, 3'd0, 1, 1, 0);
        chk(data_q == hold, "R5 surplus data", data_q, hold);
        // R12 next-address with nothing open
        hold = {63'd0, cache_q};
        tick(0, 3'd0, 0, 1, 0);
        chk({63'd0, cache_q} == hold, "R12 idle next_addr", cache_q, hold);

        // R4 burst read with back-to-back readies, plus surplus
        tick(1, 3'd2, 0, 0, 0);
        for (int i = 0; i < 5; i++) tick(0, 3'd0, 1, 0, 0);

        // R9 acknowledge pair
        tick(1, 3'd5, 0, 0, 0); tick(0, 3'd0, 1, 0, 0);
        tick(1, 3'd6, 0, 0, 0); tick(0, 3'd0, 1, 0, 0);

        // R11 write blocked, second write refused, then released
        tick(1, 3'd1, 0, 0, 1);
        tick(0, 3'd0, 1, 0, 0);
        tick(1, 3'd3, 0, 0, 0);   // refused
        chk(busy == 0, "R11 refused write", busy, 0);
        tick(0, 3'd0, 0, 0, 1);
        tick(1, 3'd3, 0, 0, 0);
        for (int i = 0; i < 4; i++) tick(0, 3'd0, 1, 1, 1);
        tick(0, 3'd0, 0, 0, 1);

        // random mix of kinds, gaps and strobes
        for (int n = 0; n < 400; n++) begin
            tick(1'($urandom % 3 == 0), 3'($urandom), 1'($urandom % 3 != 0),
                 1'($urandom % 4 == 0), 1'($urandom % 3 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule